// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point operands (1 sign bit, 8 biased exponent bits, 23 fraction bits, exponent bias 127) and returns their product. It is a fixed five-register pipeline with no stall. Once the pipeline is full it accepts one operand pair and delivers one product on every clock. A valid flag travels beside the data so that idle cycles can be mixed with busy ones.

The exponent path runs beside the significand multiplier. A 9-bit sum, which is an 8-bit add plus its carry-out, is formed first. The bias is then removed into a signed value. The significand path multiplies the two 24-bit significands, hidden one included, into a 48-bit product. The work is split across two stages as per-segment partial products followed by a shifted sum. In stage four, the top product bit acts as the normalisation flag: it selects the fraction window and adds one to the exponent. Stage five sorts the result into one of three classes: normal, zero (flush) or infinity (saturate). The packed word is built from that class.

There is no state machine. The only "states" are the three result classes `RC_NORM`, `RC_ZERO` and `RC_INF`. The class is chosen in the last stage by a decoded enum.
- RC_ZERO is chosen when an operand exponent field is zero, or when the adjusted exponent is at most 0.
- RC_INF is chosen when the adjusted exponent is at least 255.
- RC_NORM is chosen otherwise.

Top module: `fp32_mul_pipe`

## Requirements
- R1: For operands with non-zero exponent fields whose adjusted exponent lies in 1..254, the result exponent field is ea+eb-127+n. Here n is the top bit of the 48-bit significand product. The fraction is the 23 product bits directly below the leading one, truncated toward zero.
- R2: A pair presented with in_valid high appears on prod_o, with out_valid high, exactly five clock edges after the edge that samples it. Back-to-back pairs come out on back-to-back cycles.
- R3: The result sign bit (bit 31) is the XOR of the operand sign bits, for every result class.
- R4: When the significand product has bit 47 set, the fraction is taken from product bits 46..24 and the exponent is one higher. Otherwise the fraction is taken from bits 45..23.
- R5: When the adjusted exponent is 255 or more, the result is a signed infinity: exponent field all ones and fraction zero.
- R6: When the adjusted exponent is 0 or below, the result is a signed zero (bits 30..0 all zero).
- R7: An operand whose exponent field (bits 30..23) is zero is taken as zero, and the result is a signed zero.
- R8: A synchronous reset clears every stage. On the edge after reset is sampled, out_valid is 0 and prod_o is all zero.
- R9: A cycle with in_valid low produces out_valid low five edges later, whatever the operand values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair on a_i/b_i is to be multiplied |
| a_i | input | 32 | First operand, single-precision layout |
| b_i | input | 32 | Second operand, single-precision layout |
| out_valid | output | 1 | prod_o holds a product |
| prod_o | output | 32 | Product, single-precision layout |

## Verification
On every cycle, the assertions check the following:
- the five-edge valid alignment;
- the sign relation against delayed operand signs;
- that a zero-exponent operand yields a signed zero;
- that an all-ones exponent always carries a zero fraction;
- that an all-zero exponent always carries a zero fraction;
- the cleared state after reset.

The arithmetic itself can only be shown by the bench's scenarios, which compare every valid product with a computed model. This covers the exact exponent and truncated fraction, the normalisation shift, and the class boundaries at adjusted exponents 0, 1, 254 and 255, including cases where only the normalisation increment crosses a boundary.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    // Result class chosen in the final stage.
    typedef enum logic [1:0] {
        RC_NORM = 2'd0,
        RC_ZERO = 2'd1,
        RC_INF  = 2'd2
    } res_class_e;

endpackage

// File: rtl/fpm_exp_path.sv
// Exponent path, stages 2 and 3: carry-extended sum, then bias removal.
module fpm_exp_path #(
    parameter int EXP_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [EXP_W-1:0]        ea,
    input  logic [EXP_W-1:0]        eb,
    input  logic                    sign_in,
    input  logic                    zero_in,
    output logic signed [EXP_W+1:0] eunb_o,
    output logic                    sign_o,
    output logic                    zero_o
);
    localparam int SUM_W = EXP_W + 1;
    localparam int EB_W  = EXP_W + 2;
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1;

    logic [SUM_W-1:0] esum_q;
    logic             sign2_q, zero2_q;

    // Stage 2: add with carry-out kept as the ninth bit.
    always_ff @(posedge clk) begin
        if (rst) begin
            esum_q  <= '0;
            sign2_q <= 1'b0;
            zero2_q <= 1'b0;
        end else begin
            esum_q  <= {1'b0, ea} + {1'b0, eb};
            sign2_q <= sign_in;
            zero2_q <= zero_in;
        end
    end

    // Stage 3: remove the bias into a signed value.
    always_ff @(posedge clk) begin
        if (rst) begin
            eunb_o <= '0;
            sign_o <= 1'b0;
            zero_o <= 1'b0;
        end else begin
            eunb_o <= EB_W'({1'b0, esum_q}) - EB_W'(BIAS);
            sign_o <= sign2_q;
            zero_o <= zero2_q;
        end
    end

endmodule

// File: rtl/fpm_mant_mul.sv
// Significand multiplier, stages 2 and 3: segmented partial products, then sum.
module fpm_mant_mul #(
    parameter int MANT_W = 24,
    parameter int SEGS   = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [MANT_W-1:0]     ma,
    input  logic [MANT_W-1:0]     mb,
    output logic [2*MANT_W-1:0]   prod_o
);
    localparam int SEG_W  = MANT_W / SEGS;
    localparam int PP_W   = MANT_W + SEG_W;
    localparam int PROD_W = 2 * MANT_W;

    logic [SEGS-1:0][PP_W-1:0] pp_q;
    logic [PROD_W-1:0]         acc;

    // Stage 2: one partial product per multiplier segment.
    always_ff @(posedge clk) begin
        if (rst) begin
            pp_q <= '0;
        end else begin
            for (int i = 0; i < SEGS; i++) begin
                pp_q[i] <= PP_W'(ma) * PP_W'(mb[i*SEG_W +: SEG_W]);
            end
        end
    end

    always_comb begin
        acc = '0;
        for (int i = 0; i < SEGS; i++) begin
            acc = acc + (PROD_W'(pp_q[i]) << (i * SEG_W));
        end
    end

    // Stage 3: full-width product.
    always_ff @(posedge clk) begin
        if (rst) prod_o <= '0;
        else     prod_o <= acc;
    end

endmodule

// File: rtl/fpm_norm_pack.sv
// Stage 4 normalises; stage 5 selects the result class and packs the word.
module fpm_norm_pack
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [2*FRAC_W+1:0]         prod_i,
    input  logic signed [EXP_W+1:0]     eunb_i,
    input  logic                        sign_i,
    input  logic                        zero_i,
    output logic [EXP_W+FRAC_W:0]       word_o
);
    localparam int PROD_W  = 2 * (FRAC_W + 1);
    localparam int EB_W    = EXP_W + 2;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int EXP_ALL = (1 << EXP_W) - 1;

    logic                   norm4_q;
    logic [FRAC_W-1:0]      frac4_q;
    logic signed [EB_W-1:0] enorm4_q;
    logic                   sign4_q, zero4_q;
    logic                   prod_lo_unused;
    res_class_e             cls;
    logic [WORD_W-1:0]      word_d;

    assign prod_lo_unused = |prod_i[PROD_W-FRAC_W-3:0];

    // Stage 4: leading-bit normalisation and exponent increment.
    always_ff @(posedge clk) begin
        if (rst) begin
            norm4_q  <= 1'b0;
            frac4_q  <= '0;
            enorm4_q <= '0;
            sign4_q  <= 1'b0;
            zero4_q  <= 1'b0;
        end else begin
            norm4_q  <= prod_i[PROD_W-1];
            frac4_q  <= prod_i[PROD_W-1] ? prod_i[PROD_W-2 -: FRAC_W]
                                         : prod_i[PROD_W-3 -: FRAC_W];
            enorm4_q <= eunb_i + EB_W'(prod_i[PROD_W-1]);
            sign4_q  <= sign_i;
            zero4_q  <= zero_i;
        end
    end

    // Class decision from the exponent range and the zero-operand flag.
    always_comb begin
        if (zero4_q)                          cls = RC_ZERO;
        else if (int'(enorm4_q) >= EXP_ALL)   cls = RC_INF;
        else if (int'(enorm4_q) <= 0)         cls = RC_ZERO;
        else                                  cls = RC_NORM;
    end

    always_comb begin
        unique case (cls)
            RC_NORM: word_d = {sign4_q, enorm4_q[EXP_W-1:0], frac4_q};
            RC_ZERO: word_d = {sign4_q, {(WORD_W-1){1'b0}}};
            RC_INF:  word_d = {sign4_q, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            default: word_d = '0;
        endcase
    end

    // Stage 5: output register.
    always_ff @(posedge clk) begin
        if (rst) word_o <= '0;
        else     word_o <= word_d;
    end

endmodule

// File: rtl/fp32_mul_pipe.sv
// Five-stage single-precision multiplier, top level.
module fp32_mul_pipe #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int SEGS   = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] a_i,
    input  logic [31:0] b_i,
    output logic        out_valid,
    output logic [31:0] prod_o
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int MANT_W = FRAC_W + 1;
    localparam int PROD_W = 2 * MANT_W;
    localparam int STAGES = 5;

    logic [STAGES-1:0]      vld_q;
    logic                   s1_sign, s1_zero;
    logic [EXP_W-1:0]       s1_ea, s1_eb;
    logic [MANT_W-1:0]      s1_ma, s1_mb;
    logic signed [EXP_W+1:0] s3_eunb;
    logic                   s3_sign, s3_zero;
    logic [PROD_W-1:0]      s3_prod;
    logic [WORD_W-1:0]      s5_word;

    // Valid flag pipeline.
    always_ff @(posedge clk) begin
        if (rst) vld_q <= '0;
        else     vld_q <= {vld_q[STAGES-2:0], in_valid};
    end

    // Stage 1: unpack operands.
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_sign <= 1'b0;
            s1_zero <= 1'b0;
            s1_ea   <= '0;
            s1_eb   <= '0;
            s1_ma   <= '0;
            s1_mb   <= '0;
        end else begin
            s1_sign <= a_i[WORD_W-1] ^ b_i[WORD_W-1];
            s1_zero <= (a_i[WORD_W-2 -: EXP_W] == '0) || (b_i[WORD_W-2 -: EXP_W] == '0);
            s1_ea   <= a_i[WORD_W-2 -: EXP_W];
            s1_eb   <= b_i[WORD_W-2 -: EXP_W];
            s1_ma   <= {1'b1, a_i[FRAC_W-1:0]};
            s1_mb   <= {1'b1, b_i[FRAC_W-1:0]};
        end
    end

    fpm_exp_path #(.EXP_W(EXP_W)) u_exp (
        .clk     (clk),
        .rst     (rst),
        .ea      (s1_ea),
        .eb      (s1_eb),
        .sign_in (s1_sign),
        .zero_in (s1_zero),
        .eunb_o  (s3_eunb),
        .sign_o  (s3_sign),
        .zero_o  (s3_zero)
    );

    fpm_mant_mul #(.MANT_W(MANT_W), .SEGS(SEGS)) u_mul (
        .clk    (clk),
        .rst    (rst),
        .ma     (s1_ma),
        .mb     (s1_mb),
        .prod_o (s3_prod)
    );

    fpm_norm_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pack (
        .clk    (clk),
        .rst    (rst),
        .prod_i (s3_prod),
        .eunb_i (s3_eunb),
        .sign_i (s3_sign),
        .zero_i (s3_zero),
        .word_o (s5_word)
    );

    assign out_valid = vld_q[STAGES-1];
    assign prod_o    = s5_word;

endmodule

// File: rtl/fpm_checker.sv
// Temporal checks on the multiplier ports, bound into the top module.
module fpm_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] a_i,
    input logic [31:0] b_i,
    input logic        out_valid,
    input logic [31:0] prod_o
);
    localparam int LAT = 5;

    logic [LAT-1:0] vsh, ssh, zsh;
    logic           frac_in_unused;

    assign frac_in_unused = |{a_i[22:0], b_i[22:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            vsh <= '0;
            ssh <= '0;
            zsh <= '0;
        end else begin
            vsh <= {vsh[LAT-2:0], in_valid};
            ssh <= {ssh[LAT-2:0], a_i[31] ^ b_i[31]};
            zsh <= {zsh[LAT-2:0], (a_i[30:23] == 8'd0) || (b_i[30:23] == 8'd0)};
        end
    end

    // R2 / R9: valid emerges exactly five edges after it was sampled.
    a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid == vsh[LAT-1]);

    // R3: sign follows the XOR of the operand signs five edges earlier.
    a_r3_sign_xor: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> prod_o[31] == ssh[LAT-1]);

    // R7: a zero-exponent operand yields a signed zero.
    a_r7_zero_operand: assert property (@(posedge clk) disable iff (rst)
        (out_valid && zsh[LAT-1]) |-> prod_o[30:0] == 31'd0);

    // R5: an all-ones exponent only ever carries a zero fraction.
    a_r5_inf_clean: assert property (@(posedge clk) disable iff (rst)
        (out_valid && prod_o[30:23] == 8'hFF) |-> prod_o[22:0] == 23'd0);

    // R6: an all-zero exponent only ever carries a zero fraction.
    a_r6_zero_clean: assert property (@(posedge clk) disable iff (rst)
        (out_valid && prod_o[30:23] == 8'h00) |-> prod_o[22:0] == 23'd0);

    // R8: the edge after a sampled reset leaves the output cleared.
    a_r8_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && prod_o == 32'd0));

endmodule

bind fp32_mul_pipe fpm_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .a_i       (a_i),
    .b_i       (b_i),
    .out_valid (out_valid),
    .prod_o    (prod_o)
);

// File: tb/tb_fp32_mul_pipe.sv
module tb_fp32_mul_pipe;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 5;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] a_i, b_i;
    logic        out_valid;
    logic [31:0] prod_o;

    int compared = 0;
    int mismatched = 0;
    int t = 0;
    bit done = 0;

    logic        rv [8];
    logic [31:0] rp [8];
    string       rt [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    fp32_mul_pipe dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .a_i(a_i), .b_i(b_i), .out_valid(out_valid), .prod_o(prod_o)
    );

    // Model built from the requirements; tag names the governing requirement.
    function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b,
                                            output string tag);
        logic        s;
        logic [47:0] p;
        logic        n;
        logic [22:0] fr;
        int          e;
        s = a[31] ^ b[31];
        if (a[30:23] == 0 || b[30:23] == 0) begin
            tag = "R7";
            return {s, 31'd0};
        end
        p  = {24'd0, 1'b1, a[22:0]} * {24'd0, 1'b1, b[22:0]};
        n  = p[47];
        fr = n ? p[46:24] : p[45:23];
        e  = int'(a[30:23]) + int'(b[30:23]) - 127 + int'(n);
        if (e >= 255) begin tag = "R5"; return {s, 8'hFF, 23'd0}; end
        if (e <= 0)   begin tag = "R6"; return {s, 31'd0}; end
        tag = n ? "R4" : "R1";
        return {s, e[7:0], fr};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s cycle %0d actual=%h expected=%h", req, t, act, exp);
        end
    endtask

    // Check the slot that is due now, then drive a new slot.
    task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b);
        int s;
        int o;
        string tg;
        s = t % 8;
        o = (t + 8 - LAT) % 8;
        check(out_valid === rv[o], "R2/R9 valid", {31'd0, out_valid}, {31'd0, rv[o]});
        if (rv[o]) begin
            check(prod_o === rp[o], rt[o], prod_o, rp[o]);
            check(prod_o[31] === rp[o][31], "R3 sign", {31'd0, prod_o[31]}, {31'd0, rp[o][31]});
        end
        rv[s] = v;
        rp[s] = ref_mul(a, b, tg);
        rt[s] = tg;
        in_valid = v;
        a_i = a;
        b_i = b;
        t++;
        @(negedge clk);
    endtask

    function automatic logic [31:0] rnd_op();
        logic [7:0] e;
        e = 8'(1 + ($urandom % 254));
        if ($urandom % 10 == 0) e = 8'd0;
        return {1'(($urandom % 2)), e, 23'($urandom)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 8; i++) begin
            rv[i] = 1'b0;
            rp[i] = 32'd0;
            rt[i] = "none";
        end
        rst = 1'b1;
        in_valid = 1'b0;
        a_i = 32'd0;
        b_i = 32'd0;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R8 reset valid", {31'd0, out_valid}, 32'd0);
        check(prod_o === 32'd0, "R8 reset data", prod_o, 32'd0);
        // Garbage on the operands while reset is held must not leak out (R8).
        a_i = 32'h7F00_0000;
        b_i = 32'h7F00_0000;
        in_valid = 1'b1;
        @(negedge clk);
        check(prod_o === 32'd0 && out_valid === 1'b0, "R8 held reset", prod_o, 32'd0);
        in_valid = 1'b0;
        rst = 1'b0;

        // Directed corner cases.
        step(1, 32'h3F80_0000, 32'h3F80_0000);   // 1*1, R1
        step(1, 32'h3FC0_0000, 32'h3FC0_0000);   // 1.5*1.5, R4
        step(1, 32'hC000_0000, 32'h4040_0000);   // -2*3, R3
        step(1, 32'h8000_0000, 32'h3F80_0000);   // zero operand, R7
        step(0, 32'h7F00_0000, 32'h7F00_0000);   // idle with junk, R9
        step(1, 32'h7F00_0000, 32'h7F00_0000);   // overflow, R5
        step(1, 32'h0080_0000, 32'h0080_0000);   // underflow, R6
        step(1, 32'h7F00_0000, 32'h3F80_0000);   // exponent exactly 254, R1
        step(1, 32'h7F40_0000, 32'h3FC0_0000);   // increment crosses to 255, R5
        step(1, 32'h0080_0000, 32'h3F80_0000);   // exponent exactly 1, R1
        step(1, 32'h0080_0000, 32'h3F00_0000);   // exponent 0, R6
        step(1, 32'h00C0_0000, 32'h3F40_0000);   // increment lifts 0 to 1, R4
        step(1, 32'h3F80_0000, 32'h0000_1234);   // subnormal-looking operand, R7

        // Constrained random with idle gaps.
        for (int k = 0; k < 400; k++) begin
            step(1'(($urandom % 4) != 0), rnd_op(), rnd_op());
        end
        for (int k = 0; k < LAT + 1; k++) step(0, 32'd0, 32'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule